// File: doc/BRIEF.md
# Dual-Period Self-Refresh Scheduler

This block issues self-refresh operations for a memory whose wordlines are split across four array blocks that share one refresh address. A 12-bit address counter walks every wordline once per pass, advancing on each refresh tick. A retention table holds one flag per block for every address: a set flag marks a wordline whose cells hold data long enough to survive several passes without a refresh.

A programmable divider counts passes. It advances each time the top address bit falls from 1 to 0, which happens at the end of every pass. In the first p−1 passes of each group of p, a block whose wordline is flagged long has its active-low inhibit pulled low and its refresh enable withheld. In the last pass of the group, every inhibit is released and every block refreshes. Short-retention wordlines are therefore refreshed every pass, and long-retention wordlines every p passes. Each block is inhibited on its own, even though the blocks share an address.

Control is a three-state machine. IDLE (table writes accepted, no refreshes) moves to ARM when the self-refresh enable is high. ARM (one cycle: address and pass counter cleared, p captured) always moves to RUN. RUN (each tick produces one refresh) returns to IDLE when the enable drops.

Top module: `dpsr_sched`

## Requirements
- R1: After reset, ref_valid is 0, ref_en is 0, inhib_n is all ones and full_pass is 0.
- R2: A table write (tw_en high) in IDLE stores tw_data at tw_addr, where bit k set means the wordline in block k is long-retention. A table write in ARM or RUN is ignored.
- R3: Every entry into self-refresh restarts the refresh address at 0 and the pass count at 0.
- R4: A tick in RUN gives ref_valid high for exactly the next cycle, with ref_addr equal to the current address. Successive refreshes use successive addresses, wrapping modulo 4096.
- R5: In a skip pass (full_pass 0), inhib_n[k] and ref_en[k] are both 0 when the table flag for block k at ref_addr is 1, and both 1 when it is 0. Each block is decided independently.
- R6: In a full pass (full_pass 1), inhib_n and ref_en are all ones, whatever the table holds.
- R7: With captured value p, passes 0 to p−2 of each group of p are skip passes and pass p−1 is a full pass. The pass count advances when address bit 11 falls from 1 to 0.
- R8: With p equal to 1, or 0 (which is treated as 1), every pass is a full pass.
- R9: A change on p_set after ARM has no effect until the next entry into self-refresh.
- R10: In a cycle that does not follow a RUN-state tick, ref_valid and ref_en are 0. Ticks outside RUN produce no refresh and do not advance the address.
- R11: Dropping sr_en in RUN returns the machine to IDLE. From the next cycle on, no refresh is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_en | input | 1 | Self-refresh enable level |
| tick | input | 1 | Refresh request, one refresh per cycle high in RUN |
| p_set | input | 4 | Pass group length p, captured in ARM |
| tw_en | input | 1 | Retention table write enable |
| tw_addr | input | 12 | Retention table write address |
| tw_data | input | 4 | Long-retention flags, bit k for block k |
| ref_valid | output | 1 | A refresh was issued this cycle |
| ref_addr | output | 12 | Address of the refresh |
| ref_en | output | 4 | Per-block refresh enable |
| inhib_n | output | 4 | Per-block active-low inhibit |
| full_pass | output | 1 | The refresh belongs to a full pass |

## Verification
The assertions assume that tick is only meaningful in RUN, and that the table is fully written in IDLE before self-refresh starts. The bench fills every entry first, seeding corner patterns at the first and last addresses. The address-step and first-address checks assume that each entry into self-refresh goes through ARM. The stimulus enters RUN only through sr_en and issues randomly gapped ticks. It also makes out-of-state writes and changes p in mid-run, and expects both to leave the refresh stream unchanged.

// File: rtl/dpsr_pkg.sv
package dpsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } sr_state_e;
endpackage

// File: rtl/retention_table.sv
module retention_table #(
    parameter int ADDR_W = 12,
    parameter int NBLK   = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBLK-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NBLK-1:0]   rd_flags
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [NBLK-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_flags = mem[rd_addr];
endmodule

// File: rtl/refresh_addr_ctr.sv
module refresh_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              msb_fall
);
    logic [ADDR_W-1:0] addr_nx;

    assign addr_nx  = addr + 1'b1;
    assign msb_fall = step && addr[ADDR_W-1] && !addr_nx[ADDR_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (clr)  addr <= '0;
        else if (step) addr <= addr_nx;
    end
endmodule

// File: rtl/pass_divider.sv
module pass_divider #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [PW-1:0] p_in,
    input  logic          adv,
    output logic [PW-1:0] p_eff,
    output logic          long_pass
);
    logic [PW-1:0] pass_idx;
    logic [PW-1:0] last_idx;

    assign last_idx  = p_eff - 1'b1;
    assign long_pass = (pass_idx == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_eff    <= PW'(1);
            pass_idx <= '0;
        end else if (clr) begin
            p_eff    <= (p_in == '0) ? PW'(1) : p_in;
            pass_idx <= '0;
        end else if (adv) begin
            pass_idx <= long_pass ? '0 : pass_idx + 1'b1;
        end
    end
endmodule

// File: rtl/inhibit_gen.sv
module inhibit_gen #(
    parameter int NBLK = 4
) (
    input  logic [NBLK-1:0] long_flag,
    input  logic            full,
    output logic [NBLK-1:0] inh_n
);
    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        assign inh_n[k] = full | ~long_flag[k];
    end
endmodule

// File: rtl/dpsr_sched.sv
module dpsr_sched
    import dpsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NBLK   = 4,
    parameter int PW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_en,
    input  logic              tick,
    input  logic [PW-1:0]     p_set,
    input  logic              tw_en,
    input  logic [ADDR_W-1:0] tw_addr,
    input  logic [NBLK-1:0]   tw_data,
    output logic              ref_valid,
    output logic [ADDR_W-1:0] ref_addr,
    output logic [NBLK-1:0]   ref_en,
    output logic [NBLK-1:0]   inhib_n,
    output logic              full_pass
);
    sr_state_e state, state_nx;

    logic              fire;
    logic              arm;
    logic              wr_ok;
    logic [ADDR_W-1:0] addr;
    logic              msb_fall;
    logic [NBLK-1:0]   flags;
    logic [PW-1:0]     p_eff;
    logic              long_pass;
    logic [NBLK-1:0]   inh_c;

    assign fire  = (state == ST_RUN) && tick;
    assign arm   = (state == ST_ARM);
    assign wr_ok = (state == ST_IDLE) && tw_en;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (sr_en)  state_nx = ST_ARM;
            ST_ARM:              state_nx = ST_RUN;
            ST_RUN:  if (!sr_en) state_nx = ST_IDLE;
            default:             state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    retention_table #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_tab (
        .clk      (clk),
        .wr_en    (wr_ok),
        .wr_addr  (tw_addr),
        .wr_data  (tw_data),
        .rd_addr  (addr),
        .rd_flags (flags)
    );

    refresh_addr_ctr #(.ADDR_W(ADDR_W)) u_actr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (arm),
        .step     (fire),
        .addr     (addr),
        .msb_fall (msb_fall)
    );

    pass_divider #(.PW(PW)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (arm),
        .p_in      (p_set),
        .adv       (msb_fall),
        .p_eff     (p_eff),
        .long_pass (long_pass)
    );

    inhibit_gen #(.NBLK(NBLK)) u_inh (
        .long_flag (flags),
        .full      (long_pass),
        .inh_n     (inh_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            ref_addr  <= '0;
            ref_en    <= '0;
            inhib_n   <= '1;
            full_pass <= 1'b0;
        end else begin
            ref_valid <= fire;
            ref_en    <= fire ? inh_c : '0;
            if (fire) begin
                ref_addr  <= addr;
                inhib_n   <= inh_c;
                full_pass <= long_pass;
            end else if (state != ST_RUN) begin
                inhib_n   <= '1;
                full_pass <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dpsr_sched_chk.sv
module dpsr_sched_chk
    import dpsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NBLK   = 4,
    parameter int PW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input sr_state_e         state,
    input logic              ref_valid,
    input logic [ADDR_W-1:0] ref_addr,
    input logic [NBLK-1:0]   ref_en,
    input logic [NBLK-1:0]   inhib_n,
    input logic              full_pass,
    input logic [PW-1:0]     p_eff
);
    logic              have_last;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] exp_addr;

    assign exp_addr = last_addr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_addr <= '0;
        end else if (state == ST_ARM) begin
            have_last <= 1'b0;
        end else if (ref_valid) begin
            have_last <= 1'b1;
            last_addr <= ref_addr;
        end
    end

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && have_last) |-> (ref_addr == exp_addr));

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !have_last) |-> (ref_addr == '0));

    assert_full_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && full_pass) |-> (ref_en == '1 && inhib_n == '1));

    assert_p1_no_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && p_eff == PW'(1)) |-> full_pass);

    assert_quiet_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick && state == ST_RUN) |-> (!ref_valid && ref_en == '0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE) |-> !ref_valid);
endmodule

bind dpsr_sched dpsr_sched_chk #(.ADDR_W(ADDR_W), .NBLK(NBLK), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .state     (state),
    .ref_valid (ref_valid),
    .ref_addr  (ref_addr),
    .ref_en    (ref_en),
    .inhib_n   (inhib_n),
    .full_pass (full_pass),
    .p_eff     (p_eff)
);

// File: tb/dpsr_sched_tb.sv
module dpsr_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_en = 1'b0;
    logic        tick = 1'b0;
    logic [3:0]  p_set = 4'd1;
    logic        tw_en = 1'b0;
    logic [11:0] tw_addr = '0;
    logic [3:0]  tw_data = '0;
    logic        ref_valid;
    logic [11:0] ref_addr;
    logic [3:0]  ref_en;
    logic [3:0]  inhib_n;
    logic        full_pass;

    logic [3:0] shadow [DEPTH];
    int total = 0;
    int bad = 0;
    int seq = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpsr_sched u_dut (
        .clk(clk), .rst_n(rst_n), .sr_en(sr_en), .tick(tick), .p_set(p_set),
        .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
        .ref_valid(ref_valid), .ref_addr(ref_addr), .ref_en(ref_en),
        .inhib_n(inhib_n), .full_pass(full_pass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_full(input int idx, input int pe);
        return ((idx / DEPTH) % pe) == (pe - 1);
    endfunction

    task automatic start_sr(input logic [3:0] p);
        p_set = p;
        @(negedge clk) sr_en = 1'b1;
        repeat (2) @(negedge clk);
        seq = 0;
    endtask

    task automatic stop_sr();
        @(negedge clk) sr_en = 1'b0;
        @(negedge clk);
        chk("R11 ref_valid after stop", ref_valid, 0);
    endtask

    task automatic run_ticks(input int n, input int pe);
        int issued = 0;
        bit pend = 0;
        int pidx = 0;
        while (issued < n || pend) begin
            @(negedge clk);
            if (pend) begin
                int a = pidx % DEPTH;
                bit t2 = exp_full(pidx, pe);
                logic [3:0] ei = t2 ? 4'hF : ~shadow[a];
                string tg = (pe == 1) ? "R8" : (t2 ? "R6" : (a == 5 ? "R2/R5" : "R5"));
                chk("R4 ref_valid", ref_valid, 1);
                chk(pidx < 1 ? "R3 first addr" : "R4 ref_addr", ref_addr, a);
                chk({tg, " inhib_n"}, inhib_n, ei);
                chk({tg, " ref_en"}, ref_en, ei);
                chk(pe == 1 ? "R8 full_pass" : "R7 full_pass", full_pass, t2);
            end else begin
                chk("R10 ref_valid idle", ref_valid, 0);
                chk("R10 ref_en idle", ref_en, 0);
            end
            if (issued < n && ($urandom % 4) != 0) begin
                tick = 1'b1; pidx = seq; seq++; issued++; pend = 1;
            end else begin
                tick = 1'b0; pend = 0;
            end
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ref_valid", ref_valid, 0);
        chk("R1 ref_en", ref_en, 0);
        chk("R1 inhib_n", inhib_n, 4'hF);
        chk("R1 full_pass", full_pass, 0);
        rst_n = 1'b1;

        // R2: fill table in IDLE, corner patterns at the ends
        for (int i = 0; i < DEPTH; i++) begin
            logic [3:0] d = 4'($urandom);
            if (i == 0) d = 4'hF;
            if (i == 1) d = 4'b0101;
            if (i == DEPTH - 1) d = 4'h0;
            if (i == DEPTH - 2) d = 4'b1010;
            shadow[i] = d;
            @(negedge clk) begin tw_en = 1'b1; tw_addr = 12'(i); tw_data = d; end
        end
        @(negedge clk) tw_en = 1'b0;

        // Ticks in IDLE are ignored (R10)
        tick = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R10 tick in idle", ref_valid, 0);
        end
        tick = 1'b0;

        // p = 3: two skip passes then a full pass (R3 R5 R6 R7)
        start_sr(4'd3);
        // R2: write while running must be ignored
        tw_en = 1'b1; tw_addr = 12'd5; tw_data = ~shadow[5];
        @(negedge clk) tw_en = 1'b0;
        run_ticks(3 * DEPTH + 20, 3);
        stop_sr();

        // R8: p = 1 and p = 0 never skip
        start_sr(4'd1);
        run_ticks(DEPTH + 40, 1);
        stop_sr();
        start_sr(4'd0);
        run_ticks(60, 1);
        stop_sr();

        // R9 and R3: p changed mid-run, restart from address 0
        start_sr(4'd2);
        run_ticks(100, 2);
        p_set = 4'd7;
        run_ticks(2 * DEPTH + 30, 2);
        stop_sr();

        // R11: idle after stop, ticks produce nothing
        tick = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R11 no refresh in idle", ref_valid, 0);
        end
        tick = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule